// File: doc/BRIEF.md
# Storage Link Receive Handshake Controller

This block sits on the receive side of a serial storage link that moves 32-bit dwords, one per clock when `in_valid` is high. A control flag that comes with each dword marks primitives. The block does three things with that stream.

- It undoes run compression of primitives. A repeat marker stands for "the last primitive again" until a different primitive arrives.
- It picks the primitive that the local transmitter sends back each time, based on the remote side's state and on whether the local payload sink can take data.
- It collects the payload of each frame and forwards it with start and end markers.

At frame close the block reports the frame length and a CRC verdict. The last collected dword is the CRC, and it is never forwarded. Descrambling and CRC arithmetic happen outside the block. An external checker supplies a match flag (`crc_ok`), which is sampled when the frame closes.

The reply and all outputs are registered. Each valid input dword affects them exactly one clock later. Forwarded payload is held back two dwords, so the CRC can be dropped and the end marker can sit on the true last payload dword.

Top module: `lrx_frame_rx`

## Requirements
- R1: A dword is a primitive when `in_ctrl[0]` is 1, whatever the other flag bits are. All other dwords are payload. Primitive codes (hex):
  - IDLE 5A5A0001
  - TX_REQ 5A5A0002
  - RX_ACK 5A5A0003
  - FRAME_START 5A5A0004
  - FRAME_END 5A5A0005
  - TERM_WAIT 5A5A0006
  - RX_PROGRESS 5A5A0007
  - PAUSE 5A5A0008
  - PAUSE_ACK 5A5A0009
  - REPEAT 5A5A000A
  - GOOD 5A5A000B
  - BAD 5A5A000C
- R2: A received REPEAT enters repeat mode. REPEAT itself, and every later dword (payload fillers included), is treated as the last non-REPEAT primitive seen. After reset that remembered primitive is IDLE.
- R3: Any primitive other than REPEAT leaves repeat mode and becomes the new remembered primitive.
- R4: TX_REQ is answered with RX_ACK.
- R5: FRAME_START opens a new frame. If a frame is already open, its stored dwords are discarded and collection restarts.
- R6: In an open frame, each payload dword is stored. Stored dwords are forwarded in order, except the last one (the CRC). `pay_sof` marks the first forwarded dword and `pay_eof` marks the last. Payload outside a frame is dropped.
- R7: While a frame is open, payload and any primitive without its own rule (FRAME_START included) are answered with RX_PROGRESS when `sink_ready` is 1 and with PAUSE when it is 0.
- R8: PAUSE is answered with PAUSE_ACK. FRAME_END does not change the frame and takes the default reply.
- R9: TERM_WAIT on an open frame closes it. The block replies GOOD if `crc_ok` is 1 and BAD otherwise. It pulses `stat_valid` with `stat_len` set to the stored count minus one (0 if nothing was stored) and `stat_crc_err` set to the inverse of `crc_ok`. TERM_WAIT with no open frame replies GOOD and reports nothing.
- R10: When no rule above applies and no frame is open, the reply is IDLE.
- R11: The reply updates one clock after each valid dword and holds otherwise. Out of reset the reply is IDLE and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input dword present this cycle |
| in_data | input | 32 | Received dword |
| in_ctrl | input | 4 | Control flag; bit 0 marks a primitive |
| sink_ready | input | 1 | Local payload sink can accept data |
| crc_ok | input | 1 | External CRC checker verdict, sampled at frame close |
| reply | output | 32 | Primitive for the local transmitter |
| pay_valid | output | 1 | Forwarded payload dword valid |
| pay_data | output | 32 | Forwarded payload dword |
| pay_sof | output | 1 | First payload dword of the frame |
| pay_eof | output | 1 | Last payload dword of the frame |
| stat_valid | output | 1 | Frame-status pulse at close |
| stat_len | output | 12 | Payload dword count of the closed frame |
| stat_crc_err | output | 1 | Closed frame failed its CRC check |

## Verification
Directed frames cover the boundary cases:
- Zero stored dwords, where TERM_WAIT lands before any CRC.
- A CRC only.
- One payload dword, where the start and end markers coincide.
- Several payload dwords.
- A restart in mid-frame.

Repeat sequences with payload fillers, both after TX_REQ and inside a PAUSE run, show whether the filler is taken as the remembered primitive or stored as data. Seeded random frames vary `sink_ready` per dword, payload length and `crc_ok`, and add stray primitives. This separates the RX_PROGRESS/PAUSE choice and the GOOD/BAD choice from the frame bookkeeping. Idle gaps between dwords show that nothing advances without `in_valid`.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
   localparam int unsigned DWORD_W = 32;
   typedef logic [DWORD_W-1:0] dword_t;

   localparam dword_t C_IDLE        = 32'h5A5A_0001;
   localparam dword_t C_TX_REQ      = 32'h5A5A_0002;
   localparam dword_t C_RX_ACK      = 32'h5A5A_0003;
   localparam dword_t C_FRAME_START = 32'h5A5A_0004;
   localparam dword_t C_FRAME_END   = 32'h5A5A_0005;
   localparam dword_t C_TERM_WAIT   = 32'h5A5A_0006;
   localparam dword_t C_RX_PROGRESS = 32'h5A5A_0007;
   localparam dword_t C_PAUSE       = 32'h5A5A_0008;
   localparam dword_t C_PAUSE_ACK   = 32'h5A5A_0009;
   localparam dword_t C_REPEAT      = 32'h5A5A_000A;
   localparam dword_t C_GOOD        = 32'h5A5A_000B;
   localparam dword_t C_BAD         = 32'h5A5A_000C;
endpackage

// File: rtl/lrx_prim_expand.sv
module lrx_prim_expand #(
   parameter int unsigned DW       = 32,
   parameter int unsigned CW       = 4,
   parameter int unsigned PRIM_BIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [CW-1:0] in_ctrl,
   output logic          eff_prim,
   output logic [DW-1:0] eff_code
);
   import lrx_pkg::*;

   logic          raw_prim, raw_rep;
   logic          rep_q;
   logic [DW-1:0] last_q;
   logic          unused_ctrl;

   assign unused_ctrl = ^in_ctrl;
   assign raw_prim    = in_ctrl[PRIM_BIT];
   assign raw_rep     = raw_prim && (in_data == DW'(C_REPEAT));

   // R2/R3: substitute the remembered primitive while repeating
   always_comb begin
      if (raw_prim && !raw_rep) begin
         eff_prim = 1'b1;
         eff_code = in_data;
      end else if (raw_rep || rep_q) begin
         eff_prim = 1'b1;
         eff_code = last_q;
      end else begin
         eff_prim = 1'b0;
         eff_code = in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep_q  <= 1'b0;
         last_q <= DW'(C_IDLE);
      end else if (in_valid) begin
         if (raw_rep) begin
            rep_q <= 1'b1;
         end else if (raw_prim) begin
            rep_q  <= 1'b0;
            last_q <= in_data;
         end
      end
   end
endmodule

// File: rtl/lrx_reply_sel.sv
module lrx_reply_sel #(
   parameter int unsigned DW = 32
) (
   input  logic          eff_valid,
   input  logic          eff_prim,
   input  logic [DW-1:0] eff_code,
   input  logic          frame_open,
   input  logic          sink_ready,
   input  logic          crc_ok,
   output logic [DW-1:0] reply_next,
   output logic          ev_open,
   output logic          ev_close,
   output logic          ev_data
);
   import lrx_pkg::*;

   logic [DW-1:0] flow_code, dflt_code;

   assign flow_code = sink_ready ? DW'(C_RX_PROGRESS) : DW'(C_PAUSE);
   assign dflt_code = frame_open ? flow_code : DW'(C_IDLE);

   always_comb begin
      reply_next = dflt_code;
      ev_open    = 1'b0;
      ev_close   = 1'b0;
      ev_data    = eff_valid && !eff_prim && frame_open;
      if (eff_prim) begin
         if (eff_code == DW'(C_TX_REQ)) begin
            reply_next = DW'(C_RX_ACK);
         end else if (eff_code == DW'(C_PAUSE)) begin
            reply_next = DW'(C_PAUSE_ACK);
         end else if (eff_code == DW'(C_FRAME_START)) begin
            reply_next = flow_code;
            ev_open    = eff_valid;
         end else if (eff_code == DW'(C_TERM_WAIT)) begin
            reply_next = (frame_open && !crc_ok) ? DW'(C_BAD) : DW'(C_GOOD);
            ev_close   = eff_valid && frame_open;
         end
      end
   end
endmodule

// File: rtl/lrx_frame_collect.sv
module lrx_frame_collect #(
   parameter int unsigned DW    = 32,
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_open,
   input  logic             ev_close,
   input  logic             ev_data,
   input  logic [DW-1:0]    data,
   input  logic             crc_ok,
   output logic             frame_open,
   output logic             pay_valid,
   output logic [DW-1:0]    pay_data,
   output logic             pay_sof,
   output logic             pay_eof,
   output logic             stat_valid,
   output logic [LEN_W-1:0] stat_len,
   output logic             stat_crc_err
);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   logic [LEN_W-1:0] cnt_q;
   logic [DW-1:0]    older_q, newer_q;
   logic             first_q;
   logic             have_two;

   assign have_two = (cnt_q >= LEN_W'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_open   <= 1'b0;
         cnt_q        <= '0;
         older_q      <= '0;
         newer_q      <= '0;
         first_q      <= 1'b0;
         pay_valid    <= 1'b0;
         pay_data     <= '0;
         pay_sof      <= 1'b0;
         pay_eof      <= 1'b0;
         stat_valid   <= 1'b0;
         stat_len     <= '0;
         stat_crc_err <= 1'b0;
      end else begin
         pay_valid  <= 1'b0;
         pay_sof    <= 1'b0;
         pay_eof    <= 1'b0;
         stat_valid <= 1'b0;
         if (ev_open) begin
            frame_open <= 1'b1;
            cnt_q      <= '0;
            first_q    <= 1'b1;
         end else if (ev_data) begin
            if (have_two) begin
               pay_valid <= 1'b1;
               pay_data  <= older_q;
               pay_sof   <= first_q;
               first_q   <= 1'b0;
            end
            older_q <= newer_q;
            newer_q <= data;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + LEN_W'(1);
         end else if (ev_close) begin
            if (have_two) begin
               pay_valid <= 1'b1;
               pay_data  <= older_q;
               pay_sof   <= first_q;
               pay_eof   <= 1'b1;
            end
            frame_open   <= 1'b0;
            stat_valid   <= 1'b1;
            stat_len     <= (cnt_q == '0) ? '0 : cnt_q - LEN_W'(1);
            stat_crc_err <= !crc_ok;
         end
      end
   end
endmodule

// File: rtl/lrx_frame_rx.sv
module lrx_frame_rx #(
   parameter int unsigned DW       = 32,
   parameter int unsigned CW       = 4,
   parameter int unsigned PRIM_BIT = 0,
   parameter int unsigned LEN_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic [CW-1:0]    in_ctrl,
   input  logic             sink_ready,
   input  logic             crc_ok,
   output logic [DW-1:0]    reply,
   output logic             pay_valid,
   output logic [DW-1:0]    pay_data,
   output logic             pay_sof,
   output logic             pay_eof,
   output logic             stat_valid,
   output logic [LEN_W-1:0] stat_len,
   output logic             stat_crc_err
);
   import lrx_pkg::*;

   if (DW != DWORD_W) begin : g_bad_dw
      $error("lrx_frame_rx: DW must equal the package dword width");
   end
   if (PRIM_BIT >= CW) begin : g_bad_prim_bit
      $error("lrx_frame_rx: PRIM_BIT outside control flag");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("lrx_frame_rx: LEN_W too small");
   end

   logic          eff_prim;
   logic [DW-1:0] eff_code, reply_next;
   logic          ev_open, ev_close, ev_data, frame_open;

   lrx_prim_expand #(.DW(DW), .CW(CW), .PRIM_BIT(PRIM_BIT)) u_expand (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ctrl(in_ctrl), .eff_prim(eff_prim), .eff_code(eff_code));

   lrx_reply_sel #(.DW(DW)) u_sel (
      .eff_valid(in_valid), .eff_prim(eff_prim), .eff_code(eff_code),
      .frame_open(frame_open), .sink_ready(sink_ready), .crc_ok(crc_ok),
      .reply_next(reply_next), .ev_open(ev_open), .ev_close(ev_close),
      .ev_data(ev_data));

   lrx_frame_collect #(.DW(DW), .LEN_W(LEN_W)) u_collect (
      .clk(clk), .rst_n(rst_n), .ev_open(ev_open), .ev_close(ev_close),
      .ev_data(ev_data), .data(in_data), .crc_ok(crc_ok),
      .frame_open(frame_open), .pay_valid(pay_valid), .pay_data(pay_data),
      .pay_sof(pay_sof), .pay_eof(pay_eof), .stat_valid(stat_valid),
      .stat_len(stat_len), .stat_crc_err(stat_crc_err));

   // R11: reply register advances only on valid dwords
   always_ff @(posedge clk) begin
      if (!rst_n)        reply <= DW'(C_IDLE);
      else if (in_valid) reply <= reply_next;
   end
endmodule

// File: rtl/lrx_frame_rx_chk.sv
module lrx_frame_rx_chk #(
   parameter int unsigned DW       = 32,
   parameter int unsigned CW       = 4,
   parameter int unsigned PRIM_BIT = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [DW-1:0] in_data,
   input logic [CW-1:0] in_ctrl,
   input logic [DW-1:0] reply,
   input logic          pay_valid,
   input logic          pay_sof,
   input logic          pay_eof,
   input logic          stat_valid,
   input logic          stat_crc_err
);
   import lrx_pkg::*;

   logic raw_req, raw_pause, raw_rep;
   assign raw_req   = in_valid && in_ctrl[PRIM_BIT] && (in_data == DW'(C_TX_REQ));
   assign raw_pause = in_valid && in_ctrl[PRIM_BIT] && (in_data == DW'(C_PAUSE));
   assign raw_rep   = in_valid && in_ctrl[PRIM_BIT] && (in_data == DW'(C_REPEAT));

   p_markers_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_sof || pay_eof) |-> pay_valid);

   p_req_gets_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      raw_req |=> (reply == DW'(C_RX_ACK)));

   p_pause_gets_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_pause |=> (reply == DW'(C_PAUSE_ACK)));

   p_repeat_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_rep && $past(raw_req)) |=> (reply == DW'(C_RX_ACK)));

   p_status_matches_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (reply == (stat_crc_err ? DW'(C_BAD) : DW'(C_GOOD))));

   p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(reply) && !pay_valid && !stat_valid));
endmodule

bind lrx_frame_rx lrx_frame_rx_chk #(.DW(DW), .CW(CW), .PRIM_BIT(PRIM_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .in_ctrl(in_ctrl), .reply(reply), .pay_valid(pay_valid),
   .pay_sof(pay_sof), .pay_eof(pay_eof), .stat_valid(stat_valid),
   .stat_crc_err(stat_crc_err));

// File: tb/lrx_frame_rx_tb.sv
module lrx_frame_rx_tb;
   import lrx_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic [3:0]  in_ctrl = '0;
   logic        sink_ready = 1'b1;
   logic        crc_ok = 1'b1;
   logic [31:0] reply, pay_data;
   logic        pay_valid, pay_sof, pay_eof, stat_valid, stat_crc_err;
   logic [11:0] stat_len;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   bit          m_rep = 0;
   logic [31:0] m_last = C_IDLE;
   bit          m_open = 0;
   bit          m_first = 0;
   logic [31:0] m_q[$];

   always #5 clk = ~clk;

   lrx_frame_rx u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ctrl(in_ctrl), .sink_ready(sink_ready), .crc_ok(crc_ok),
      .reply(reply), .pay_valid(pay_valid), .pay_data(pay_data),
      .pay_sof(pay_sof), .pay_eof(pay_eof), .stat_valid(stat_valid),
      .stat_len(stat_len), .stat_crc_err(stat_crc_err));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] d, input logic [3:0] c, input bit rdy,
                       input bit crc, input string tag);
      bit ep; logic [31:0] ec, flow, e_reply, e_pd;
      bit e_pv, e_sof, e_eof, e_sv, e_err; int e_len;
      ep = 0; ec = d; e_pv = 0; e_sof = 0; e_eof = 0; e_sv = 0; e_err = 0;
      e_len = 0; e_pd = '0;
      if (c[0] && d != C_REPEAT) begin
         ep = 1; ec = d; m_last = d; m_rep = 0;
      end else if ((c[0] && d == C_REPEAT) || m_rep) begin
         ep = 1; ec = m_last; m_rep = 1;
      end
      flow = rdy ? C_RX_PROGRESS : C_PAUSE;
      e_reply = m_open ? flow : C_IDLE;
      if (ep) begin
         if (ec == C_TX_REQ) e_reply = C_RX_ACK;
         else if (ec == C_PAUSE) e_reply = C_PAUSE_ACK;
         else if (ec == C_FRAME_START) begin
            e_reply = flow; m_open = 1; m_first = 1; m_q.delete();
         end else if (ec == C_TERM_WAIT) begin
            if (m_open) begin
               e_reply = crc ? C_GOOD : C_BAD;
               if (m_q.size() >= 2) begin
                  e_pv = 1; e_pd = m_q[m_q.size()-2]; e_sof = m_first; e_eof = 1;
               end
               e_sv = 1; e_err = !crc;
               e_len = (m_q.size() == 0) ? 0 : m_q.size() - 1;
               m_open = 0;
            end else e_reply = C_GOOD;
         end
      end else if (m_open) begin
         if (m_q.size() >= 2) begin
            e_pv = 1; e_pd = m_q[m_q.size()-2]; e_sof = m_first; m_first = 0;
         end
         m_q.push_back(d);
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_ctrl = c; sink_ready = rdy; crc_ok = crc;
      @(posedge clk);
      #1;
      chk(reply == e_reply, tag, "reply", reply, e_reply);
      chk(pay_valid == e_pv, tag, "pay_valid", 32'(pay_valid), 32'(e_pv));
      if (e_pv && pay_valid) begin
         chk(pay_data == e_pd, tag, "pay_data", pay_data, e_pd);
         chk(pay_sof == e_sof && pay_eof == e_eof, tag, "sof/eof",
             {30'd0, pay_sof, pay_eof}, {30'd0, e_sof, e_eof});
      end
      chk(stat_valid == e_sv, tag, "stat_valid", 32'(stat_valid), 32'(e_sv));
      if (e_sv && stat_valid) begin
         chk(32'(stat_len) == 32'(e_len), "R9", "stat_len", 32'(stat_len), 32'(e_len));
         chk(stat_crc_err == e_err, "R9", "stat_crc_err", 32'(stat_crc_err), 32'(e_err));
      end
   endtask

   task automatic idle(input int n);
      logic [31:0] held;
      @(negedge clk);
      in_valid = 1'b0;
      held = reply;
      for (int i = 0; i < n; i++) begin
         in_data = $urandom; in_ctrl = 4'(($urandom)); crc_ok = $urandom_range(0, 1);
         @(posedge clk); #1;
         chk(reply == held && !pay_valid && !stat_valid, "R11", "idle hold",
             reply, held);
         @(negedge clk);
      end
   endtask

   task automatic prim(input logic [31:0] code, input string tag);
      step(code, 4'b0001, 1'b1, 1'b1, tag);
   endtask

   task automatic pay(input logic [31:0] d, input string tag);
      step(d, 4'b0000, 1'b1, 1'b1, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(reply == C_IDLE, "R11", "reset reply", reply, C_IDLE);
      chk(!pay_valid && !stat_valid, "R11", "reset pulses",
          {30'd0, pay_valid, stat_valid}, 32'd0);

      // R10 / R6: payload outside a frame, nothing open
      pay(32'h1234_5678, "R10");
      step(32'hDEAD_0000, 4'b1110, 1'b1, 1'b1, "R1");   // upper flag bits only: payload
      step(32'h0BAD_C0DE, 4'b0001, 1'b1, 1'b1, "R1");   // unknown primitive: default
      prim(C_TERM_WAIT, "R9");                          // no open frame
      // R4 and R2: handshake, then repeat with payload filler
      prim(C_TX_REQ, "R4");
      prim(C_REPEAT, "R2");
      pay(32'hFFFF_0001, "R2");
      idle(3);
      // several payload dwords
      prim(C_FRAME_START, "R5");
      pay(32'hA000_0001, "R6"); pay(32'hA000_0002, "R6");
      pay(32'hA000_0003, "R6"); pay(32'hC4C4_C4C4, "R6");
      prim(C_FRAME_END, "R8");
      prim(C_TERM_WAIT, "R9");
      // single payload dword: sof and eof together
      prim(C_FRAME_START, "R5"); pay(32'hB000_0001, "R6"); pay(32'hC0C0_0000, "R6");
      prim(C_TERM_WAIT, "R9");
      // empty frames
      prim(C_FRAME_START, "R5"); prim(C_TERM_WAIT, "R9");
      prim(C_FRAME_START, "R5"); pay(32'hC1C1_0000, "R6"); prim(C_TERM_WAIT, "R9");
      // restart in mid-frame
      prim(C_FRAME_START, "R5"); pay(32'hD000_0001, "R5"); pay(32'hD000_0002, "R5");
      prim(C_FRAME_START, "R5"); pay(32'hD000_0003, "R5"); pay(32'hC2C2_0000, "R5");
      prim(C_TERM_WAIT, "R5");
      // CRC failure and back-pressure
      prim(C_FRAME_START, "R5");
      step(32'hE000_0001, 4'b0000, 1'b0, 1'b1, "R7");
      prim(C_PAUSE, "R8"); prim(C_REPEAT, "R3"); pay(32'hFFFF_FFFF, "R3");
      prim(C_PAUSE, "R3");
      step(32'hE000_0002, 4'b0000, 1'b1, 1'b1, "R7");
      step(32'hC3C3_0000, 4'b0000, 1'b1, 1'b0, "R7");
      step(C_TERM_WAIT, 4'b0001, 1'b1, 1'b0, "R9");
      prim(C_IDLE, "R10");
      idle(2);

      // seeded random frames
      for (int f = 0; f < 120; f++) begin
         int n;
         prim(C_TX_REQ, "R4");
         if ($urandom_range(0, 3) == 0) begin
            prim(C_REPEAT, "R2"); pay($urandom, "R2");
         end
         prim(C_FRAME_START, "R5");
         n = $urandom_range(0, 7);
         for (int k = 0; k < n; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) begin
               prim(C_PAUSE, "R8"); prim(C_REPEAT, "R3"); pay($urandom, "R3");
               prim(C_PAUSE, "R3");
            end else if (r == 1) begin
               step(C_RX_PROGRESS + 32'($urandom_range(0, 2)), 4'b0001,
                    1'($urandom_range(0, 1)), 1'b1, "R7");
            end
            step($urandom, 4'(($urandom)) & 4'b1110, 1'($urandom_range(0, 1)),
                 1'b1, "R6");
         end
         prim(C_FRAME_END, "R8");
         step(C_TERM_WAIT, 4'b0001, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), "R9");
         if ($urandom_range(0, 2) == 0) prim(C_IDLE, "R10");
         if ($urandom_range(0, 4) == 0) idle(2);
      end
      idle(2);
      finish_run();
   end
endmodule